// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is a 16-bit arithmetic and logic unit with no clock inside its datapath. It also holds a small registered status word. Each cycle it takes two operands, a 3-bit operation code, an operand-size select and a carry-in. It returns a result together with six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. The supported operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR and NOT. In byte mode only the low eight bits of the operands take part, and the upper half of the result is forced to zero.

A nine-bit flag register sits next to the datapath. Its six condition bits capture the live flags on a clock edge only when the flag-write enable is high. Its three control bits (single-step trap, interrupt enable, string direction) change only through their own write port, so arithmetic never disturbs them. Both writes may happen in the same cycle, and they then act independently. The register is cleared by an asynchronous active-low reset whose release is synchronised to the clock.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 adds, and code 1 adds plus `cin_i`. `cf_o` is the carry out of the top bit of the selected size: bit 15 when `word_i`=1, bit 7 when `word_i`=0.
- R2: Code 2 subtracts B from A, and code 3 also subtracts `cin_i` as a borrow. `cf_o` is 1 exactly when the unsigned A is less than B plus the borrow.
- R3: `of_o` is 1 when the signed result of an add or subtract falls outside the signed range of the selected size.
- R4: `af_o` is 1 when an add carries, or a subtract borrows, from bit 3 into bit 4, for both sizes.
- R5: `pf_o` is 1 when bits 7..0 of the result hold an even number of ones, also for word operations.
- R6: `zf_o` is 1 exactly when the sized result is zero. `sf_o` is bit 15 (word) or bit 7 (byte) of the result. In byte mode, `result_o[15:8]` is 0.
- R7: Codes 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT A, and force `cf_o`, `of_o` and `af_o` to 0. `cin_i` affects only codes 1 and 3.
- R8: `flags_q_o[5:0]` = {of, sf, zf, af, pf, cf} (bit 0 is carry) loads the live flags on a rising edge when `flag_we_i`=1 and holds its value otherwise.
- R9: `flags_q_o[8:6]` = {direction, interrupt enable, trap} loads `ctrl_wdata_i` (same bit order) only when `ctrl_we_i`=1. When both enables are high in one cycle, each field takes its own new value.
- R10: While `rst_n` is low, all nine bits of `flags_q_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| op_i | input | 3 | Operation code (0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 and, 5 or, 6 xor, 7 not A) |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| cin_i | input | 1 | Carry / borrow input for codes 1 and 3 |
| flag_we_i | input | 1 | Capture condition flags at the next edge |
| ctrl_we_i | input | 1 | Write control flags at the next edge |
| ctrl_wdata_i | input | 3 | New control flags {direction, interrupt enable, trap} |
| result_o | output | 16 | Result |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Parity flag (low byte, even ones) |
| af_o | output | 1 | Auxiliary carry from bit 3 |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |
| flags_q_o | output | 9 | Registered flags {dir, ie, trap, of, sf, zf, af, pf, cf} |

## Verification
A condition-flag capture and a control-flag write can land on the same clock edge. In that case one register must take two unrelated fields from two different sources. The stimulus sets both enables independently on every cycle of a long pseudo-random run, with varied operands and operations, so both-high cycles occur many times alongside cycles with only one enable or none. The bench model builds the expected register value from that cycle's computed flags and write data. It compares all nine bits just after the edge, so a lost or crossed field shows up in the very cycle it happens.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned COND_N = 6;
  localparam int unsigned CTRL_N = 3;
  localparam int unsigned FLAG_N = COND_N + CTRL_N;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_NOT = 3'd7
  } alu_op_e;

  // Packed so that cry lands on bit 0 and ovf on bit 5
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } cond_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cry_o,
  output logic              aux_o,
  output logic              ovf_o
);

  localparam int unsigned EXT_W = DATA_W + 1;
  localparam int unsigned HI_W  = DATA_W - BYTE_W;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [EXT_W-1:0]  full;
  logic              c_into_nib;
  logic              c_into_bmsb;
  logic              c_outof_b;
  logic              c_into_wmsb;

  always_comb begin
    // Subtraction is A + ~B + ~borrow; carry sense is inverted at the end
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ^ cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + EXT_W'(c_eff);

    // Carry into bit k recovered from sum and operand bits
    c_into_nib  = full[NIB_W]    ^ a_i[NIB_W]    ^ b_eff[NIB_W];
    c_into_bmsb = full[BYTE_W-1] ^ a_i[BYTE_W-1] ^ b_eff[BYTE_W-1];
    c_outof_b   = full[BYTE_W]   ^ a_i[BYTE_W]   ^ b_eff[BYTE_W];
    c_into_wmsb = full[DATA_W-1] ^ a_i[DATA_W-1] ^ b_eff[DATA_W-1];

    aux_o = c_into_nib ^ sub_i;

    if (word_i) begin
      sum_o = full[DATA_W-1:0];
      cry_o = full[DATA_W] ^ sub_i;
      ovf_o = full[DATA_W] ^ c_into_wmsb;
    end else begin
      sum_o = {{HI_W{1'b0}}, full[BYTE_W-1:0]};
      cry_o = c_outof_b ^ sub_i;
      ovf_o = c_outof_b ^ c_into_bmsb;
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int unsigned HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] size_mask;

  always_comb begin
    unique case (sel_i)
      2'd0:    raw = a_i & b_i;
      2'd1:    raw = a_i | b_i;
      2'd2:    raw = a_i ^ b_i;
      default: raw = ~a_i;
    endcase
    size_mask = word_i ? {DATA_W{1'b1}} : {{HI_W{1'b0}}, {BYTE_W{1'b1}}};
    res_o     = raw & size_mask;
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              word_i,
  input  logic              arith_i,
  input  logic              cry_i,
  input  logic              aux_i,
  input  logic              ovf_i,
  output cond_t             flags_o
);

  always_comb begin
    flags_o.par = ~^res_i[BYTE_W-1:0];
    flags_o.zro = (res_i == '0);
    flags_o.sgn = word_i ? res_i[DATA_W-1] : res_i[BYTE_W-1];
    flags_o.cry = arith_i & cry_i;
    flags_o.aux = arith_i & aux_i;
    flags_o.ovf = arith_i & ovf_i;
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cond_we_i,
  input  cond_t             cond_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_N-1:0] ctrl_i,
  output logic [FLAG_N-1:0] flags_o
);

  logic [FLAG_N-1:0] flags_d;
  logic [FLAG_N-1:0] flags_q;

  always_comb begin
    flags_d = flags_q;
    if (cond_we_i) flags_d[COND_N-1:0]      = cond_i;
    if (ctrl_we_i) flags_d[FLAG_N-1:COND_N] = ctrl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        opa_i,
  input  logic [DATA_W-1:0]        opb_i,
  input  logic [2:0]               op_i,
  input  logic                     word_i,
  input  logic                     cin_i,
  input  logic                     flag_we_i,
  input  logic                     ctrl_we_i,
  input  logic [CTRL_N-1:0]        ctrl_wdata_i,
  output logic [DATA_W-1:0]        result_o,
  output logic                     cf_o,
  output logic                     pf_o,
  output logic                     af_o,
  output logic                     zf_o,
  output logic                     sf_o,
  output logic                     of_o,
  output logic [FLAG_N-1:0]        flags_q_o
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_sync_n;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_sync_n = sync_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // Operation decode
  alu_op_e op;
  logic    is_arith;
  logic    is_sub;
  logic    use_cin;

  always_comb begin
    op       = alu_op_e'(op_i);
    is_arith = 1'b0;
    is_sub   = 1'b0;
    use_cin  = 1'b0;
    unique case (op)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; use_cin = 1'b1; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBB: begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
      default: ;
    endcase
  end

  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic              a_cry;
  logic              a_aux;
  logic              a_ovf;
  cond_t             live_flags;

  alu_addsub #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .NIB_W  (NIB_W)
  ) u_addsub (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (is_sub),
    .cin_i  (use_cin & cin_i),
    .word_i (word_i),
    .sum_o  (arith_res),
    .cry_o  (a_cry),
    .aux_o  (a_aux),
    .ovf_o  (a_ovf)
  );

  alu_logic #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_logic (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sel_i  (op_i[1:0]),
    .word_i (word_i),
    .res_o  (logic_res)
  );

  assign result_o = is_arith ? arith_res : logic_res;

  alu_flag_gen #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_flag_gen (
    .res_i   (result_o),
    .word_i  (word_i),
    .arith_i (is_arith),
    .cry_i   (a_cry),
    .aux_i   (a_aux),
    .ovf_i   (a_ovf),
    .flags_o (live_flags)
  );

  assign cf_o = live_flags.cry;
  assign pf_o = live_flags.par;
  assign af_o = live_flags.aux;
  assign zf_o = live_flags.zro;
  assign sf_o = live_flags.sgn;
  assign of_o = live_flags.ovf;

  alu_flag_reg u_flag_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cond_we_i (flag_we_i),
    .cond_i    (live_flags),
    .ctrl_we_i (ctrl_we_i),
    .ctrl_i    (ctrl_wdata_i),
    .flags_o   (flags_q_o)
  );

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic              word_i,
  input logic              flag_we_i,
  input logic              ctrl_we_i,
  input logic [2:0]        ctrl_wdata_i,
  input logic [DATA_W-1:0] result_o,
  input logic              cf_o,
  input logic              pf_o,
  input logic              af_o,
  input logic              zf_o,
  input logic              sf_o,
  input logic              of_o,
  input logic [8:0]        flags_q_o
);

  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_i[2] |-> (!cf_o && !of_o && !af_o));

  p_byte_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_i |-> (result_o[DATA_W-1:BYTE_W] == '0));

  p_zero_not_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zf_o |-> !sf_o);

  p_cond_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_q_o[5:0]));

  p_cond_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (flags_q_o[5:0] == $past({of_o, sf_o, zf_o, af_o, pf_o, cf_o})));

  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we_i |=> $stable(flags_q_o[8:6]));

  p_ctrl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we_i |=> (flags_q_o[8:6] == $past(ctrl_wdata_i)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .op_i         (op_i),
  .word_i       (word_i),
  .flag_we_i    (flag_we_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .result_o     (result_o),
  .cf_o         (cf_o),
  .pf_o         (pf_o),
  .af_o         (af_o),
  .zf_o         (zf_o),
  .sf_o         (sf_o),
  .of_o         (of_o),
  .flags_q_o    (flags_q_o)
);

// File: tb/test_alu_flag_unit.sv
`timescale 1ns/1ps
module test_alu_flag_unit;

  logic        clk;
  logic        rst_n;
  logic [15:0] opa, opb;
  logic [2:0]  op;
  logic        word, cin, fwe, cwe;
  logic [2:0]  cdata;
  logic [15:0] result;
  logic        cf, pf, af, zf, sf, of_f;
  logic [8:0]  flags_q;

  int errors = 0;
  int checks = 0;
  logic [8:0] exp_q;

  typedef struct {
    logic [15:0] r;
    logic [5:0]  f;
    logic [8:0]  q;
    string       tag;
  } item_t;

  item_t sb_q[$];

  alu_flag_unit i_alu_flag_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .opa_i        (opa),
    .opb_i        (opb),
    .op_i         (op),
    .word_i       (word),
    .cin_i        (cin),
    .flag_we_i    (fwe),
    .ctrl_we_i    (cwe),
    .ctrl_wdata_i (cdata),
    .result_o     (result),
    .cf_o         (cf),
    .pf_o         (pf),
    .af_o         (af),
    .zf_o         (zf),
    .sf_o         (sf),
    .of_o         (of_f),
    .flags_q_o    (flags_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: integer arithmetic straight from the requirements
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [2:0] o,
                       input logic w, input logic ci,
                       output logic [15:0] r, output logic [5:0] f);
    int m, msb, ai, bi, c, full, sa, sb, s;
    logic c_f, a_f, o_f;
    m   = w ? 32'hFFFF : 32'hFF;
    msb = w ? 15 : 7;
    ai  = int'(a) & m;
    bi  = int'(b) & m;
    c   = (o == 3'd1 || o == 3'd3) ? int'(ci) : 0;
    sa  = ((ai >> msb) & 1) != 0 ? ai - (m + 1) : ai;
    sb  = ((bi >> msb) & 1) != 0 ? bi - (m + 1) : bi;
    c_f = 1'b0; a_f = 1'b0; o_f = 1'b0;
    case (o)
      3'd0, 3'd1: begin
        full = ai + bi + c;
        r    = 16'(full & m);
        c_f  = full > m;
        a_f  = ((ai & 15) + (bi & 15) + c) > 15;
        s    = sa + sb + c;
        o_f  = (s > (m >> 1)) || (s < -((m >> 1) + 1));
      end
      3'd2, 3'd3: begin
        full = ai - bi - c;
        r    = 16'(full & m);
        c_f  = full < 0;
        a_f  = (ai & 15) < ((bi & 15) + c);
        s    = sa - sb - c;
        o_f  = (s > (m >> 1)) || (s < -((m >> 1) + 1));
      end
      3'd4:    r = 16'((ai & bi) & m);
      3'd5:    r = 16'((ai | bi) & m);
      3'd6:    r = 16'((ai ^ bi) & m);
      default: r = 16'((~ai) & m);
    endcase
    // {of, sf, zf, af, pf, cf}
    f = {o_f, r[msb], (r == 16'h0), a_f, ($countones(r[7:0]) % 2 == 0), c_f};
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [2:0] o,
                       input logic w, input logic ci, input logic fw, input logic cw,
                       input logic [2:0] cd, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    opa = a; opb = b; op = o; word = w; cin = ci;
    fwe = fw; cwe = cw; cdata = cd;
    model(a, b, o, w, ci, it.r, it.f);
    if (fw) exp_q[5:0] = it.f;
    if (cw) exp_q[8:6] = cd;
    it.q   = exp_q;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    fwe = 1'b0;
    cwe = 1'b0;
  endtask

  // Monitor: pops one expected item per edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (result !== it.r) begin
          errors++;
          $display("FAIL %s result: got %h expected %h", it.tag, result, it.r);
        end
        checks++;
        if ({of_f, sf, zf, af, pf, cf} !== it.f) begin
          errors++;
          $display("FAIL %s flags {of,sf,zf,af,pf,cf}: got %b expected %b",
                   it.tag, {of_f, sf, zf, af, pf, cf}, it.f);
        end
        checks++;
        if (flags_q !== it.q) begin
          errors++;
          $display("FAIL %s flag register (R8/R9): got %b expected %b", it.tag, flags_q, it.q);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    opa = '0; opb = '0; op = '0; word = 1'b1; cin = 1'b0;
    fwe = 1'b0; cwe = 1'b0; cdata = '0;
    exp_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (flags_q !== 9'h0) begin
      errors++;
      $display("FAIL R10 reset state: got %b expected %b", flags_q, 9'h0);
    end

    // Add, word and byte
    drive(16'h1234, 16'h4321, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R1 add word, cin ignored");
    drive(16'hFFFF, 16'h0001, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R1/R4/R6 add word wrap to zero");
    drive(16'h12FF, 16'h3401, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R1/R6 add byte carry, upper zero");
    drive(16'h007F, 16'h0001, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R3/R4 add byte overflow");
    drive(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R3 add word overflow");
    drive(16'h00FE, 16'h0001, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R1 add with carry byte");
    drive(16'h000F, 16'h0000, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R4 adc nibble carry");
    // Subtract
    drive(16'h0005, 16'h0007, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R2 sub word borrow");
    drive(16'h0080, 16'h0001, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R3 sub byte overflow");
    drive(16'h8000, 16'h0001, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R3 sub word overflow");
    drive(16'h0010, 16'h0001, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R4 sub nibble borrow");
    drive(16'h4444, 16'h4444, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R6 sub equal zero");
    drive(16'h0005, 16'h0005, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, "R2 sbb byte borrow-in");
    drive(16'h0000, 16'h0000, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R2 sbb zero minus borrow");
    // Logic
    drive(16'hF0F0, 16'hFF00, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R7 and word");
    drive(16'hF0F0, 16'h0F0F, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R7 or word");
    drive(16'hAAAA, 16'hFFFF, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R7 xor byte");
    drive(16'h00FF, 16'h0000, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, "R7 not word");
    drive(16'h1200, 16'h0000, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R7 not byte");
    // Parity from low byte only
    drive(16'h0100, 16'h0000, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R5 parity ignores upper byte");
    drive(16'h0301, 16'h0000, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, "R5 parity odd low byte");
    // Register behaviour
    drive(16'hFFFF, 16'h0001, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, "R8 hold without enable");
    drive(16'h0001, 16'h0002, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'b101, "R9 control write only");
    drive(16'h0000, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b010, "R9 flag write keeps control");
    drive(16'h8000, 16'h8000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'b010, "R9 both writes same cycle");
    drive(16'h0000, 16'h0000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, "R9 ctrl data ignored when disabled");

    // Pseudo-random mix, both enables independent
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      drive(16'($urandom), 16'($urandom), rv[2:0], rv[3], rv[4], rv[5], rv[6], rv[9:7],
            "R1-mix random (R1 R2 R3 R4 R5 R6 R7 R8 R9)");
    end

    idle();
    repeat (3) @(negedge clk);
    drive(16'h0000, 16'h0001, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'b111, "R10 preload before reset");
    idle();
    repeat (2) @(negedge clk);
    #5;
    rst_n = 1'b0;
    #1;
    checks++;
    if (flags_q !== 9'h0) begin
      errors++;
      $display("FAIL R10 asynchronous clear: got %b expected %b", flags_q, 9'h0);
    end
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule